// File: doc/BRIEF.md
# Two-Phase Data Bus Interface

This block sits between the core of a small 8-bit processor and its bidirectional data pins. The processor runs from one system clock that carries two non-overlapping phase enables. The block holds three registers. The outgoing data register loads during phase one. The incoming data latch and the predecode (opcode) register both load during phase two. A pad controller turns the pin driver on only in the phase-two half of a write cycle. The address bus is output-only and is handled elsewhere; this block covers only the data path.

Every bus cycle is either a read or a write. On a read, phase two captures the value arriving at the pins. On a write, the value the block is driving comes straight back into the input latch and the predecode register, so both always hold the last value seen on the bus whatever its direction. The predecode register carries a valid flag for the core. The flag is raised only by a read that the core has marked as an opcode fetch.

The core-facing data paths follow a valid-only stream rule. The predecode output carries `pdec_vld` and has no ready signal, because a bus cycle cannot stall. The core must take the value before the next phase two, which overwrites it. The pad itself (tristate buffer) sits outside this block and is controlled by `pad_oe`.

Top module: `dbus_twophase_if`

## Requirements
- R1: While `rst_n` is low, `in_hold`, `pdec_byte`, `pdec_vld`, `pad_oe` and `pad_dout` are all 0, and so is the internal outgoing register. This holds even if `ph2_en` and `bus_wr` are high during reset.
- R2: On a clock edge where `ph1_en` is 1, the outgoing register takes `core_wdata`. On any other edge it keeps its value. This value is observed on `pad_dout` during the next write phase two.
- R3: `pad_oe` is 1 exactly when `bus_wr` is 1 (write; 0 means read) and `ph2_en` is 1. At that time `pad_dout` equals the outgoing register. At all other times `pad_dout` is 0.
- R4: On a clock edge with `ph2_en` high and `bus_wr` low, `in_hold` and `pdec_byte` both take `pad_din`. The new values are visible after that edge.
- R5: On a clock edge with `ph2_en` high and `bus_wr` high, `in_hold` and `pdec_byte` both take the outgoing register value, and `pad_din` is ignored.
- R6: On edges with `ph2_en` low, `in_hold`, `pdec_byte` and `pdec_vld` keep their values, whatever `pad_din` does.
- R7: On each phase-two edge, `pdec_vld` becomes 1 if the cycle is a read with `op_fetch` high, and 0 otherwise.
- R8: `ph1_en` and `ph2_en` are never high in the same cycle. During the phase-one half of a write cycle the pins stay released (`pad_oe` is 0).
- R9: A change of `core_wdata` while `ph1_en` is low has no effect on what a later write drives onto the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1_en | input | 1 | Phase-one enable pulse |
| ph2_en | input | 1 | Phase-two enable pulse |
| bus_wr | input | 1 | Cycle direction: 1 write, 0 read |
| op_fetch | input | 1 | Read cycle is an opcode fetch |
| core_wdata | input | DW | Internal bus value to send out |
| pad_din | input | DW | Value arriving from the data pads |
| pad_oe | output | 1 | Drive enable for the pad tristate buffers |
| pad_dout | output | DW | Value for the pad drivers |
| in_hold | output | DW | Input data latch contents for the core |
| pdec_byte | output | DW | Predecode register contents |
| pdec_vld | output | 1 | Predecode register holds a fetched opcode |

## Verification
The hardest case to reach from the ports is a write loopback that is also told apart from a read. The value captured must come from the outgoing register, loaded one phase earlier, and not from the pads. The stimulus therefore loads one byte in phase one, drives a different, deliberately conflicting byte on `pad_din` during the write phase two, and then checks which byte the latch holds. A second scenario changes `core_wdata` with `ph1_en` low between cycles. It then shows that the pins still carry the byte loaded earlier, which separates a correct phase-one load from a register that follows its input or loads on the wrong phase.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_e;

  function automatic cyc_e to_cyc(input logic wr);
    return wr ? CYC_WRITE : CYC_READ;
  endfunction
endpackage

// File: rtl/dbus_out_reg.sv
module dbus_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph1_en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  // Outgoing data register: loads only in phase one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (ph1_en) q <= d;
  end
endmodule

// File: rtl/dbus_pad_ctrl.sv
module dbus_pad_ctrl #(
  parameter int DW = 8
) (
  input  logic           rst_n,
  input  dbus_pkg::cyc_e cyc,
  input  logic           ph2_en,
  input  logic [DW-1:0]  odr,
  output logic           pad_oe,
  output logic [DW-1:0]  pad_dout
);
  import dbus_pkg::*;

  logic drive;

  // Pins are driven only in the phase-two half of a write; reset forces off.
  always_comb begin
    drive    = rst_n && (cyc == CYC_WRITE) && ph2_en;
    pad_oe   = drive;
    pad_dout = drive ? odr : '0;
  end
endmodule

// File: rtl/dbus_in_capture.sv
module dbus_in_capture #(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ph2_en,
  input  dbus_pkg::cyc_e cyc,
  input  logic           op_fetch,
  input  logic [DW-1:0]  pad_din,
  input  logic [DW-1:0]  odr,
  output logic [DW-1:0]  in_hold,
  output logic [DW-1:0]  pdec_byte,
  output logic           pdec_vld
);
  import dbus_pkg::*;

  logic [DW-1:0] bus_val;
  logic          opc_mark;

  // The value present on the bus in phase two: our own drive on a write,
  // the pads on a read.
  always_comb begin
    bus_val  = (cyc == CYC_WRITE) ? odr : pad_din;
    opc_mark = (cyc == CYC_READ) && op_fetch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold   <= '0;
      pdec_byte <= '0;
      pdec_vld  <= 1'b0;
    end else if (ph2_en) begin
      in_hold   <= bus_val;
      pdec_byte <= bus_val;
      pdec_vld  <= opc_mark;
    end
  end
endmodule

// File: rtl/dbus_twophase_if.sv
module dbus_twophase_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph1_en,
  input  logic          ph2_en,
  input  logic          bus_wr,
  input  logic          op_fetch,
  input  logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] pad_din,
  output logic          pad_oe,
  output logic [DW-1:0] pad_dout,
  output logic [DW-1:0] in_hold,
  output logic [DW-1:0] pdec_byte,
  output logic          pdec_vld
);
  import dbus_pkg::*;

  cyc_e          cyc;
  logic [DW-1:0] odr_q;

  assign cyc = to_cyc(bus_wr);

  dbus_out_reg #(.DW(DW)) u_odr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph1_en (ph1_en),
    .d      (core_wdata),
    .q      (odr_q)
  );

  dbus_pad_ctrl #(.DW(DW)) u_pad (
    .rst_n    (rst_n),
    .cyc      (cyc),
    .ph2_en   (ph2_en),
    .odr      (odr_q),
    .pad_oe   (pad_oe),
    .pad_dout (pad_dout)
  );

  dbus_in_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph2_en    (ph2_en),
    .cyc       (cyc),
    .op_fetch  (op_fetch),
    .pad_din   (pad_din),
    .odr       (odr_q),
    .in_hold   (in_hold),
    .pdec_byte (pdec_byte),
    .pdec_vld  (pdec_vld)
  );
endmodule

// File: rtl/dbus_twophase_if_chk.sv
module dbus_twophase_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph1_en,
  input logic          ph2_en,
  input logic          bus_wr,
  input logic          op_fetch,
  input logic [DW-1:0] pad_din,
  input logic          pad_oe,
  input logic [DW-1:0] pad_dout,
  input logic [DW-1:0] in_hold,
  input logic [DW-1:0] pdec_byte,
  input logic          pdec_vld
);
  // R8: phases never overlap
  a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_en && ph2_en));

  // R3: driver enabled only in a write phase two
  a_r3_oe_only_write_ph2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (bus_wr && ph2_en));

  // R3: released pins carry zero
  a_r3_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> (pad_dout == '0));

  // R5: write loopback captures what was driven
  a_r5_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && bus_wr) |=> (in_hold == $past(pad_dout)) && (pdec_byte == $past(pad_dout)));

  // R4: read captures the pads
  a_r4_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && !bus_wr) |=> (in_hold == $past(pad_din)) && (pdec_byte == $past(pad_din)));

  // R6: no phase two, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2_en |=> $stable(in_hold) && $stable(pdec_byte) && $stable(pdec_vld));

  // R7: opcode valid follows a fetch read
  a_r7_vld: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_en |=> (pdec_vld == $past(!bus_wr && op_fetch)));
endmodule

bind dbus_twophase_if dbus_twophase_if_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ph1_en    (ph1_en),
  .ph2_en    (ph2_en),
  .bus_wr    (bus_wr),
  .op_fetch  (op_fetch),
  .pad_din   (pad_din),
  .pad_oe    (pad_oe),
  .pad_dout  (pad_dout),
  .in_hold   (in_hold),
  .pdec_byte (pdec_byte),
  .pdec_vld  (pdec_vld)
);

// File: tb/dbus_twophase_if_bench.sv
module dbus_twophase_if_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ph1_en = 1'b0, ph2_en = 1'b0, bus_wr = 1'b0, op_fetch = 1'b0;
  logic [DW-1:0] core_wdata = '0, pad_din = '0;
  logic          pad_oe, pdec_vld;
  logic [DW-1:0] pad_dout, in_hold, pdec_byte;

  int total = 0;
  int bad   = 0;

  // expected model, from the requirements
  logic [DW-1:0] m_odr = '0, m_hold = '0;
  logic          m_vld = 1'b0;

  always #5 clk = ~clk;

  dbus_twophase_if #(.DW(DW)) u_dbus_twophase_if (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .bus_wr(bus_wr), .op_fetch(op_fetch), .core_wdata(core_wdata),
    .pad_din(pad_din), .pad_oe(pad_oe), .pad_dout(pad_dout),
    .in_hold(in_hold), .pdec_byte(pdec_byte), .pdec_vld(pdec_vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check({req, " in_hold"},   32'(in_hold),   32'(m_hold));
    check({req, " pdec_byte"}, 32'(pdec_byte), 32'(m_hold));
    check({req, " pdec_vld"},  32'(pdec_vld),  32'(m_vld));
  endtask

  // One full bus cycle: phase one then phase two. Inputs change at negedge.
  task automatic bus_cycle(input logic wr, input logic fetch,
                           input logic [DW-1:0] wdat, input logic [DW-1:0] din,
                           input string req);
    @(negedge clk);
    ph1_en = 1'b1; ph2_en = 1'b0; bus_wr = wr; op_fetch = fetch;
    core_wdata = wdat; pad_din = din;
    #1;
    check({req, " R8 pins released in phase one"}, 32'(pad_oe), 32'd0);
    @(posedge clk);
    m_odr = wdat;
    @(negedge clk);
    ph1_en = 1'b0; ph2_en = 1'b1;
    #1;
    check({req, " R3 oe"}, 32'(pad_oe), 32'(wr));
    check({req, " R3 dout"}, 32'(pad_dout), wr ? 32'(m_odr) : 32'd0);
    @(posedge clk);
    m_hold = wr ? m_odr : din;
    m_vld  = !wr && fetch;
    #1;
    check_regs(req);
    @(negedge clk);
    ph2_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ph1_en = 1'b0; bus_wr = 1'b1; ph2_en = 1'b1;
    #1;
    m_odr = '0; m_hold = '0; m_vld = 1'b0;
    check("R1 oe in reset", 32'(pad_oe), 32'd0);
    check("R1 dout in reset", 32'(pad_dout), 32'd0);
    check_regs("R1");
    @(negedge clk);
    ph2_en = 1'b0; bus_wr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_reads();
    bus_cycle(1'b0, 1'b1, 8'h11, 8'hA9, "R4 R7 fetch read");
    bus_cycle(1'b0, 1'b0, 8'h22, 8'h3C, "R4 R7 data read");
    bus_cycle(1'b0, 1'b1, 8'h33, 8'hFF, "R4 fetch read ff");
    bus_cycle(1'b0, 1'b0, 8'h44, 8'h00, "R4 read zero");
  endtask

  task automatic t_write_loopback();
    bus_cycle(1'b1, 1'b0, 8'h5A, 8'hC3, "R5 write loopback");
    bus_cycle(1'b1, 1'b1, 8'h81, 8'h7E, "R5 R7 write with fetch flag");
  endtask

  task automatic t_no_ph1_load();
    // R2 R9: core_wdata moves while ph1 is low; the write must show the old byte
    bus_cycle(1'b0, 1'b0, 8'h6D, 8'h12, "R2 preload");
    @(negedge clk);
    core_wdata = 8'hEE;
    @(negedge clk);
    core_wdata = 8'h99;
    ph2_en = 1'b1; bus_wr = 1'b1;
    #1;
    check("R9 dout keeps phase-one byte", 32'(pad_dout), 32'h6D);
    check("R2 oe", 32'(pad_oe), 32'd1);
    @(posedge clk);
    m_hold = 8'h6D; m_vld = 1'b0;
    #1;
    check_regs("R9 loopback of held byte");
    @(negedge clk);
    ph2_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_hold();
    bus_cycle(1'b0, 1'b1, 8'h01, 8'h4B, "R6 setup");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pad_din = 8'(8'h90 + i);
      bus_wr = i[0];
      op_fetch = ~i[0];
      @(posedge clk);
      #1;
      check_regs("R6 hold without ph2");
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_oe_gating();
    @(negedge clk);
    bus_wr = 1'b1; ph2_en = 1'b0;
    #1;
    check("R3 write without ph2", 32'(pad_oe), 32'd0);
    check("R3 dout quiet", 32'(pad_dout), 32'd0);
    @(negedge clk);
    bus_wr = 1'b0; ph2_en = 1'b1; pad_din = 8'h24;
    #1;
    check("R3 read in ph2", 32'(pad_oe), 32'd0);
    @(posedge clk);
    m_hold = 8'h24; m_vld = op_fetch;
    #1;
    check_regs("R4 read in gating test");
    @(negedge clk);
    ph2_en = 1'b0;
  endtask

  task automatic t_reset_mid();
    bus_cycle(1'b1, 1'b0, 8'hB7, 8'h00, "R5 before reset");
    do_reset();
    bus_cycle(1'b1, 1'b0, 8'h00, 8'h55, "R1 R5 after reset");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_reads();
    t_write_loopback();
    t_no_ph1_load();
    t_hold();
    t_oe_gating();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule